// File: doc/BRIEF.md
# Parallel Converter Host Sequencer

This block drives a 16-bit successive-approximation converter with a parallel output from the host side. It controls the converter's active-low chip select, its read/convert line and its lane-swap line. Inside the converter, chip select and read/convert are combined by OR. The sequencer therefore starts a conversion by pulling both lines low together. It then waits for the converter's busy line to fall and rise again. After that it lowers chip select with read/convert held high, which enables the converter's data drivers, and it samples the result.

A conversion is requested in one of two ways: by a single-cycle start pulse, or by a free-running rate counter when automatic mode is enabled. Busy reaches the sequencer through a two-flop synchronizer. A request that arrives while the synchronized busy is low, or while a conversion is already in progress, is dropped.

The result can be read in two ways. The first reads all 16 data lines at once. The second reads an 8-bit host bus in two phases: it reads the low lane with the lane-swap line low, then again with it high. The 16-bit result is a two's complement code and is presented with a one-cycle valid strobe. A sticky error flag reports a conversion whose busy line never returned high in time.

Top module: `adc_par_host`

## Requirements
- R1: While reset is asserted, chip select is high, read/convert is high, lane-swap is low, valid is low and the error flag is low.
- R2: An accepted request drives chip select and read/convert low together for exactly PULSE_CYC cycles. Both then return high.
- R3: A request is ignored unless the synchronized busy is high and the sequencer is idle. No chip-select or read/convert edge follows an ignored request.
- R4: In wide mode (narrow_i=0), chip select goes low with read/convert high once busy has risen. All 16 lines are sampled after SETTLE_CYC cycles. Valid pulses for one cycle, 3+SETTLE_CYC cycles after busy rises.
- R5: In narrow mode (narrow_i=1), bits 7:0 of the data bus are sampled twice, SETTLE_CYC cycles apart: first with lane-swap low (this gives the low byte), then with lane-swap high (this gives the high byte). The result is {second, first}. Valid comes 3+2*SETTLE_CYC cycles after busy rises. Lane-swap is high only while chip select is low and read/convert is high.
- R6: With auto_en_i high, the sequencer issues a conversion every RATE_CYC cycles.
- R7: If busy has not returned high TIMEOUT_CYC cycles after the start pulse ends, the error flag is set and the sequencer returns to idle with both control lines high. The flag clears when the next request is accepted.
- R8: res_data_o is a two's complement code: 16'h7FFF reads as +32767 and 16'h8000 reads as -32768. Read/convert is never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle conversion request |
| auto_en_i | input | 1 | Enable for the periodic rate trigger |
| narrow_i | input | 1 | 1 = two-phase 8-bit read, 0 = 16-bit read |
| adc_busy_i | input | 1 | Converter busy line (low while converting), asynchronous |
| adc_data_i | input | 16 | Converter data bus |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rc_o | output | 1 | Converter read/convert line |
| adc_byte_o | output | 1 | Converter lane-swap select |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| res_data_o | output | 16 | Last result, two's complement |
| timeout_err_o | output | 1 | Sticky conversion timeout flag |

## Verification
Each result's arrival is measured against the cycle in which the converter model raises busy. Valid must appear exactly 3+SETTLE_CYC cycles later in wide mode and 3+2*SETTLE_CYC cycles later in narrow mode. These cycles cover two synchronizer stages, one decision register and the settle counts. The model also measures each start pulse's width at the converter pins and the spacing between automatic starts, and it compares both with their exact cycle counts. The timeout flag is checked after a window well beyond TIMEOUT_CYC. All observations are taken on the falling clock edge, once the registered outputs have settled.

// File: rtl/adc_par_host_pkg.sv
package adc_par_host_pkg;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_CONV,
        HS_ACK,
        HS_WAIT,
        HS_RDLO,
        HS_RDHI
    } host_st_e;

endpackage

// File: rtl/adc_par_host_sync.sv
module adc_par_host_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/adc_par_host_rate.sv
module adc_par_host_rate #(
    parameter int RATE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int RW = $clog2(RATE_CYC + 1);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          tick;
    } rate_s;

    rate_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.tick = 1'b0;
        if (!en_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == RW'(RATE_CYC - 1)) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick_o = r_q.tick;
endmodule

// File: rtl/adc_par_host_fsm.sv
module adc_par_host_fsm
    import adc_par_host_pkg::*;
#(
    parameter int DW          = 16,
    parameter int PULSE_CYC   = 2,
    parameter int SETTLE_CYC  = 3,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic          narrow_i,
    input  logic          busy_s_i,
    input  logic [DW-1:0] data_i,
    output logic          cs_n_o,
    output logic          rc_o,
    output logic          byte_o,
    output logic          vld_o,
    output logic [DW-1:0] res_o,
    output logic          err_o
);
    localparam int BW   = DW / 2;
    localparam int MAXC = (TIMEOUT_CYC > SETTLE_CYC) ?
                          ((TIMEOUT_CYC > PULSE_CYC) ? TIMEOUT_CYC : PULSE_CYC) :
                          ((SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        host_st_e      st;
        logic [CW-1:0] cnt;
        logic          cs_n;
        logic          rc;
        logic          byt;
        logic          narrow;
        logic [BW-1:0] lo;
        logic [DW-1:0] res;
        logic          vld;
        logic          err;
    } fsm_s;

    fsm_s f_d, f_q;

    always_comb begin
        f_d = f_q;
        f_d.vld = 1'b0;
        case (f_q.st)
            HS_IDLE: begin
                f_d.cs_n = 1'b1;
                f_d.rc   = 1'b1;
                f_d.byt  = 1'b0;
                if (trig_i && busy_s_i) begin
                    f_d.st     = HS_CONV;
                    f_d.cnt    = '0;
                    f_d.cs_n   = 1'b0;
                    f_d.rc     = 1'b0;
                    f_d.narrow = narrow_i;
                    f_d.err    = 1'b0;
                end
            end
            HS_CONV: begin
                if (f_q.cnt == CW'(PULSE_CYC - 1)) begin
                    f_d.st   = HS_ACK;
                    f_d.cnt  = '0;
                    f_d.cs_n = 1'b1;
                    f_d.rc   = 1'b1;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            HS_ACK: begin
                f_d.cnt = f_q.cnt + 1'b1;
                if (!busy_s_i) f_d.st = HS_WAIT;
                if (f_q.cnt == CW'(TIMEOUT_CYC - 1)) begin
                    f_d.st  = HS_IDLE;
                    f_d.cnt = '0;
                    f_d.err = 1'b1;
                end
            end
            HS_WAIT: begin
                if (busy_s_i) begin
                    f_d.st   = HS_RDLO;
                    f_d.cnt  = '0;
                    f_d.cs_n = 1'b0;
                    f_d.rc   = 1'b1;
                    f_d.byt  = 1'b0;
                end else if (f_q.cnt == CW'(TIMEOUT_CYC - 1)) begin
                    f_d.st  = HS_IDLE;
                    f_d.cnt = '0;
                    f_d.err = 1'b1;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            HS_RDLO: begin
                if (f_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    f_d.cnt = '0;
                    if (f_q.narrow) begin
                        f_d.lo  = data_i[BW-1:0];
                        f_d.st  = HS_RDHI;
                        f_d.byt = 1'b1;
                    end else begin
                        f_d.res  = data_i;
                        f_d.vld  = 1'b1;
                        f_d.st   = HS_IDLE;
                        f_d.cs_n = 1'b1;
                    end
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            HS_RDHI: begin
                if (f_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    f_d.cnt  = '0;
                    f_d.res  = {data_i[BW-1:0], f_q.lo};
                    f_d.vld  = 1'b1;
                    f_d.st   = HS_IDLE;
                    f_d.cs_n = 1'b1;
                    f_d.byt  = 1'b0;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            default: begin
                f_d.st   = HS_IDLE;
                f_d.cs_n = 1'b1;
                f_d.rc   = 1'b1;
                f_d.byt  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q      <= '0;
            f_q.st   <= HS_IDLE;
            f_q.cs_n <= 1'b1;
            f_q.rc   <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign cs_n_o = f_q.cs_n;
    assign rc_o   = f_q.rc;
    assign byte_o = f_q.byt;
    assign vld_o  = f_q.vld;
    assign res_o  = f_q.res;
    assign err_o  = f_q.err;
endmodule

// File: rtl/adc_par_host.sv
module adc_par_host #(
    parameter int DW          = 16,
    parameter int PULSE_CYC   = 2,
    parameter int SETTLE_CYC  = 3,
    parameter int TIMEOUT_CYC = 64,
    parameter int RATE_CYC    = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          auto_en_i,
    input  logic          narrow_i,
    input  logic          adc_busy_i,
    input  logic [DW-1:0] adc_data_i,
    output logic          adc_cs_n_o,
    output logic          adc_rc_o,
    output logic          adc_byte_o,
    output logic          res_valid_o,
    output logic [DW-1:0] res_data_o,
    output logic          timeout_err_o
);
    logic busy_s;
    logic rate_tick;
    logic trig;

    adc_par_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (adc_busy_i),
        .sync_o  (busy_s)
    );

    adc_par_host_rate #(.RATE_CYC(RATE_CYC)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (auto_en_i),
        .tick_o (rate_tick)
    );

    assign trig = start_i | rate_tick;

    adc_par_host_fsm #(
        .DW          (DW),
        .PULSE_CYC   (PULSE_CYC),
        .SETTLE_CYC  (SETTLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig),
        .narrow_i (narrow_i),
        .busy_s_i (busy_s),
        .data_i   (adc_data_i),
        .cs_n_o   (adc_cs_n_o),
        .rc_o     (adc_rc_o),
        .byte_o   (adc_byte_o),
        .vld_o    (res_valid_o),
        .res_o    (res_data_o),
        .err_o    (timeout_err_o)
    );
endmodule

// File: rtl/adc_par_host_chk.sv
module adc_par_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rc,
    input logic byt,
    input logic vld,
    input logic err,
    input logic busy_s
);
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (cs_n && rc && !byt && !vld && !err) || !rst_n);

    a_r8_rc_low_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !rc |-> !cs_n);

    a_r5_byte_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        byt |-> (!cs_n && rc));

    a_r3_start_needs_busy_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc) |-> $past(busy_s));

    a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (cs_n && rc));
endmodule

bind adc_par_host adc_par_host_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (adc_cs_n_o),
    .rc     (adc_rc_o),
    .byt    (adc_byte_o),
    .vld    (res_valid_o),
    .err    (timeout_err_o),
    .busy_s (busy_s)
);

// File: tb/test_adc_par_host.sv
module test_adc_par_host;
    localparam int PULSE   = 2;
    localparam int SETTLE  = 3;
    localparam int TMO     = 64;
    localparam int RATE    = 100;
    localparam int CONVLEN = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        auto_en_i = 1'b0;
    logic        narrow_i = 1'b0;
    logic        adc_busy;
    logic [15:0] adc_data;
    logic        cs_n, rc, byt, vld, err;
    logic [15:0] res;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    adc_par_host i_adc_par_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .auto_en_i     (auto_en_i),
        .narrow_i      (narrow_i),
        .adc_busy_i    (adc_busy),
        .adc_data_i    (adc_data),
        .adc_cs_n_o    (cs_n),
        .adc_rc_o      (rc),
        .adc_byte_o    (byt),
        .res_valid_o   (vld),
        .res_data_o    (res),
        .timeout_err_o (err)
    );

    // converter model controls
    logic        hold_low = 1'b0;
    logic        hang = 1'b0;
    logic        auto_words = 1'b0;
    logic [15:0] word_in = 16'h0000;

    // converter model state
    logic        busy_int;
    logic [15:0] out_word;
    logic [15:0] word_cur;
    logic [15:0] ofs;
    logic        prev_or;
    logic        in_pulse;
    logic        hang_st;
    int          pulse_cnt;
    int          conv_cnt;
    int          ncyc;
    int          n_starts;
    int          n_valid;
    int          last_start;
    logic        have_auto_start;
    logic [15:0] exp_q[$];
    int          rise_q[$];

    assign adc_busy = busy_int && !hold_low;
    assign adc_data = (!cs_n && rc) ?
                      (byt ? {out_word[7:0], out_word[15:8]} : out_word) : 16'hDEAD;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(negedge clk) begin
        logic cur_or;
        int lat;
        logic [15:0] e;
        int rt;
        if (!rst_n) begin
            busy_int <= 1'b1; out_word <= 16'h0; word_cur <= 16'h0; ofs <= 16'h0;
            prev_or <= 1'b1; in_pulse <= 1'b0; hang_st <= 1'b0;
            pulse_cnt <= 0; conv_cnt <= 0; ncyc <= 0; n_starts <= 0; n_valid <= 0;
            last_start <= 0; have_auto_start <= 1'b0;
        end else begin
            cur_or = cs_n | rc;
            if (!auto_en_i) have_auto_start <= 1'b0;
            if (prev_or && !cur_or) begin
                n_starts <= n_starts + 1;
                chk(adc_busy == 1'b1, "R3", "start while busy low", 0, 1);
                if (auto_en_i && have_auto_start)
                    chk(ncyc - last_start == RATE, "R6", "auto start spacing",
                        ncyc - last_start, RATE);
                if (auto_en_i) have_auto_start <= 1'b1;
                last_start <= ncyc;
                in_pulse  <= 1'b1;
                pulse_cnt <= 1;
                busy_int  <= 1'b0;
                if (hang) begin
                    hang_st <= 1'b1;
                end else begin
                    conv_cnt <= CONVLEN;
                    word_cur <= auto_words ? word_in + ofs : word_in;
                    ofs      <= ofs + 16'h1111;
                end
            end else begin
                if (in_pulse) begin
                    if (!cur_or) pulse_cnt <= pulse_cnt + 1;
                    else begin
                        chk(pulse_cnt == PULSE, "R2", "start pulse width", pulse_cnt, PULSE);
                        in_pulse <= 1'b0;
                    end
                end
                if (conv_cnt > 0) begin
                    conv_cnt <= conv_cnt - 1;
                    if (conv_cnt == 1) begin
                        busy_int <= 1'b1;
                        out_word <= word_cur;
                        exp_q.push_back(word_cur);
                        rise_q.push_back(ncyc);
                    end
                end
                if (hang_st && !hang) begin
                    busy_int <= 1'b1;
                    hang_st  <= 1'b0;
                end
            end
            if (vld) begin
                n_valid <= n_valid + 1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "valid without conversion", 1, 0);
                end else begin
                    e  = exp_q.pop_front();
                    rt = rise_q.pop_front();
                    lat = narrow_i ? 3 + 2 * SETTLE : 3 + SETTLE;
                    chk(res == e, narrow_i ? "R5" : "R4", "result", res, e);
                    chk(ncyc - rt == lat, narrow_i ? "R5" : "R4", "valid latency",
                        ncyc - rt, lat);
                end
            end
            prev_or <= cur_or;
            ncyc <= ncyc + 1;
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 100000);
            finish_run();
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic convert(input logic [15:0] w, input string req);
        int nv;
        word_in = w;
        nv = n_valid;
        pulse_start();
        for (int i = 0; i < 200 && n_valid == nv; i++) @(negedge clk);
        @(negedge clk);
        chk(n_valid == nv + 1, req, "conversion completed", n_valid - nv, 1);
    endtask

    initial begin
        int ns;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        chk(rc == 1'b1, "R1", "rc in reset", rc, 1);
        chk(byt == 1'b0, "R1", "byte in reset", byt, 0);
        chk(vld == 1'b0, "R1", "valid in reset", vld, 0);
        chk(err == 1'b0, "R1", "err in reset", err, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 wide reads, R8 two's complement codes
        narrow_i = 1'b0;
        convert(16'h1234, "R4");
        convert(16'h7FFF, "R8");
        chk($signed(res) == 32767, "R8", "max positive code", $signed(res), 32767);
        convert(16'h8000, "R8");
        chk($signed(res) == -32768, "R8", "most negative code", $signed(res), -32768);
        convert(16'hFFFF, "R4");
        chk(rc == 1'b1 && cs_n == 1'b1, "R8", "bus released after read", {cs_n, rc}, 3);

        // R5 narrow two-phase reads
        narrow_i = 1'b1;
        convert(16'hA55A, "R5");
        convert(16'h00FF, "R5");
        convert(16'h8001, "R5");
        narrow_i = 1'b0;

        // R3 request ignored while busy held low
        hold_low = 1'b1;
        repeat (4) @(negedge clk);
        ns = n_starts;
        pulse_start();
        repeat (20) begin
            @(negedge clk);
            chk(cs_n == 1'b1 && rc == 1'b1, "R3", "lines idle while busy low", {cs_n, rc}, 3);
        end
        chk(n_starts == ns, "R3", "no start issued", n_starts - ns, 0);
        hold_low = 1'b0;
        repeat (4) @(negedge clk);

        // R7 timeout
        hang = 1'b1;
        pulse_start();
        repeat (TMO + 40) @(negedge clk);
        chk(err == 1'b1, "R7", "timeout flag", err, 1);
        chk(cs_n == 1'b1 && rc == 1'b1, "R7", "idle after timeout", {cs_n, rc}, 3);
        chk(exp_q.size() == 0, "R7", "no result pending", exp_q.size(), 0);
        hang = 1'b0;
        repeat (4) @(negedge clk);
        convert(16'h5A5A, "R7");
        chk(err == 1'b0, "R7", "flag cleared by next start", err, 0);

        // R6 automatic rate
        auto_words = 1'b1;
        word_in = 16'h0F0F;
        ns = n_starts;
        auto_en_i = 1'b1;
        repeat (4 * RATE + 20) @(negedge clk);
        auto_en_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(n_starts - ns == 4, "R6", "auto conversions", n_starts - ns, 4);
        chk(exp_q.size() == 0, "R6", "all auto results delivered", exp_q.size(), 0);

        finish_run();
    end
endmodule